// File: doc/BRIEF.md
# Two-Source SPI Transaction Arbiter with Gain-Controller Priority

This block lets two independent command sources share a single SPI controller port that faces an RF transceiver. One source is the automatic gain controller, which must change front-end gains quickly. The other is the host or soft-processor command path. Each source raises a request and holds an address, write data and a read/write flag steady until it sees its completion strobe. The arbiter picks one source per transaction, copies that source's fields onto the master port, pulses a start strobe, and waits for the master's completion. It then routes the completion strobe and read data back to the winning source alone.

When both sources request in the same decision cycle, the gain controller wins. A streak counter keeps the host from starving. It counts the gain controller's back-to-back wins taken while the host was also waiting. Once that count reaches `MAX_GAIN_STREAK`, the next contested decision goes to the host. A grant is never pulled back mid-transaction.

The sequencer has four named states. `ST_IDLE` has no grant and arbitrates. `ST_LAUNCH` holds the grant and pulses `m_start` for one cycle. `ST_BUSY` holds the grant and waits for `m_done`. `ST_RELEASE` is a one-cycle gap with no grant. Its transitions are as follows:
- Seeing a request moves `ST_IDLE` to `ST_LAUNCH`.
- `ST_LAUNCH` always moves to `ST_BUSY`.
- `m_done` moves `ST_BUSY` to `ST_RELEASE`.
- `ST_RELEASE` always moves to `ST_IDLE`.
- With no request, `ST_IDLE` stays in `ST_IDLE`.

Top module: `spi_req_arbiter`

## Requirements
- R1: While reset is held and on the first cycle after it, neither grant is high, `m_start` is low and both completion strobes are low.
- R2: A request from exactly one source is seen at an idle clock edge. On the next cycle that source's grant is high and `m_start` is high for exactly one cycle. `m_addr`, `m_wdata` and `m_wr` equal that source's fields.
- R3: Both sources are seen requesting at an idle edge and the streak count is below `MAX_GAIN_STREAK`. The gain controller is then granted.
- R4: Suppose the gain controller has won `MAX_GAIN_STREAK` (default 3) grants in a row, each while the host was requesting. The next grant then goes to the host. A host grant, or a gain grant with no host request, clears the count.
- R5: From the start cycle until the cycle of `m_done`, at most one grant is high. The grant and the master fields do not change, whatever the sources do in that time.
- R6: `m_done` may arrive while a transaction is in flight. The owner's completion strobe is then high in that same cycle, and its read data equals `m_rdata`. The other source's strobe is low and its read data is zero. Read data to a source is zero whenever its strobe is low.
- R7: An `m_done` outside a transaction in flight produces no completion strobe and does not alter the sequence.
- R8: After the completion cycle there is one cycle with no grant. The arbiter then decides again. With no request pending it keeps both grants low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gain_req | input | 1 | Gain-controller request, held until its done |
| gain_addr | input | ADDR_W | Gain-controller register address |
| gain_wdata | input | DATA_W | Gain-controller write data |
| gain_wr | input | 1 | Gain-controller write (1) or read (0) |
| gain_grant | output | 1 | Gain controller owns the master port |
| gain_done | output | 1 | Completion strobe to the gain controller |
| gain_rdata | output | DATA_W | Read data to the gain controller |
| host_req | input | 1 | Host request, held until its done |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_wr | input | 1 | Host write (1) or read (0) |
| host_grant | output | 1 | Host owns the master port |
| host_done | output | 1 | Completion strobe to the host |
| host_rdata | output | DATA_W | Read data to the host |
| m_start | output | 1 | One-cycle start pulse to the SPI master |
| m_addr | output | ADDR_W | Address to the SPI master |
| m_wdata | output | DATA_W | Write data to the SPI master |
| m_wr | output | 1 | Read/write flag to the SPI master |
| m_done | input | 1 | Completion pulse from the SPI master |
| m_rdata | input | DATA_W | Read data from the SPI master |

## Verification
Two functions can land in the same cycle. The first is returning a completion to one source while the other source raises or holds a request. The second is a contested decision where both requests are seen at one idle edge, possibly alongside a stray `m_done`. A seeded random mix with a dense phase, in which both sources re-request at once, provokes this. A sparse phase then leaves the arbiter idle while stray completions arrive. A bench model of the four-state sequence and the streak rule predicts the grant and the steering each cycle. It compares the ports against that prediction, and a final check confirms that the host-after-streak case actually occurred.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_BUSY    = 2'd2,
        ST_RELEASE = 2'd3
    } arb_state_t;

    typedef enum logic {
        OWN_GAIN = 1'b0,
        OWN_HOST = 1'b1
    } owner_t;

    localparam int NUM_SRC = 2;

endpackage

// File: rtl/spi_arb_pick.sv
module spi_arb_pick
    import spi_arb_pkg::*;
#(
    parameter int MAX_GAIN_STREAK = 3
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   gain_req,
    input  logic   host_req,
    input  logic   take,
    output logic   pick_valid,
    output owner_t pick_owner
);
    localparam int STREAK_W = $clog2(MAX_GAIN_STREAK + 1);
    localparam logic [STREAK_W-1:0] STREAK_CAP = STREAK_W'(MAX_GAIN_STREAK);

    logic [STREAK_W-1:0] streak_q;
    logic                cap_hit;

    assign cap_hit    = (streak_q >= STREAK_CAP);
    assign pick_valid = gain_req | host_req;

    always_comb begin
        if (gain_req && host_req) begin
            pick_owner = cap_hit ? OWN_HOST : OWN_GAIN;
        end else if (gain_req) begin
            pick_owner = OWN_GAIN;
        end else begin
            pick_owner = OWN_HOST;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            streak_q <= '0;
        end else if (take) begin
            if (pick_owner == OWN_GAIN && host_req) begin
                streak_q <= cap_hit ? streak_q : streak_q + 1'b1;
            end else begin
                streak_q <= '0;
            end
        end
    end

    assert_streak_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        streak_q <= STREAK_CAP);

    assert_lone_host_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !gain_req) |=> (streak_q == '0));

endmodule

// File: rtl/spi_arb_seq.sv
module spi_arb_seq
    import spi_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pick_valid,
    input  owner_t pick_owner,
    input  logic   m_done,
    output logic   take,
    output logic   m_start,
    output logic   busy,
    output owner_t owner_q,
    output logic   gain_grant,
    output logic   host_grant
);
    arb_state_t state_q, state_d;
    logic       holding;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (pick_valid) state_d = ST_LAUNCH;
            ST_LAUNCH:  state_d = ST_BUSY;
            ST_BUSY:    if (m_done) state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= OWN_GAIN;
        end else begin
            state_q <= state_d;
            if (take) owner_q <= pick_owner;
        end
    end

    always_comb begin
        take    = 1'b0;
        m_start = 1'b0;
        busy    = 1'b0;
        holding = 1'b0;
        unique case (state_q)
            ST_IDLE:    take = pick_valid;
            ST_LAUNCH:  begin m_start = 1'b1; holding = 1'b1; end
            ST_BUSY:    begin busy = 1'b1; holding = 1'b1; end
            ST_RELEASE: ;
        endcase
        gain_grant = holding && (owner_q == OWN_GAIN);
        host_grant = holding && (owner_q == OWN_HOST);
    end

    assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        m_start |=> !m_start);

    assert_owner_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_start || (busy && !m_done)) |=> ($stable(owner_q) && (gain_grant || host_grant)));

    assert_release_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && m_done) |=> (!gain_grant && !host_grant && !m_start));

    assert_stray_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (m_start && m_done) |=> busy);

endmodule

// File: rtl/spi_arb_route.sv
module spi_arb_route
    import spi_arb_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           take,
    input  owner_t                         pick_owner,
    input  owner_t                         owner_q,
    input  logic                           busy,
    input  logic [NUM_SRC-1:0][ADDR_W-1:0] src_addr,
    input  logic [NUM_SRC-1:0][DATA_W-1:0] src_wdata,
    input  logic [NUM_SRC-1:0]             src_wr,
    input  logic                           m_done,
    input  logic [DATA_W-1:0]              m_rdata,
    output logic [ADDR_W-1:0]              m_addr,
    output logic [DATA_W-1:0]              m_wdata,
    output logic                           m_wr,
    output logic [NUM_SRC-1:0]             src_done,
    output logic [NUM_SRC-1:0][DATA_W-1:0] src_rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_addr  <= '0;
            m_wdata <= '0;
            m_wr    <= 1'b0;
        end else if (take) begin
            m_addr  <= src_addr[pick_owner];
            m_wdata <= src_wdata[pick_owner];
            m_wr    <= src_wr[pick_owner];
        end
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_return
        assign src_done[i]  = busy && m_done && (owner_q == owner_t'(i));
        assign src_rdata[i] = src_done[i] ? m_rdata : '0;
    end

    assert_fields_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !m_done) |=> ($stable(m_addr) && $stable(m_wdata) && $stable(m_wr)));

    assert_single_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_done));

endmodule

// File: rtl/spi_req_arbiter.sv
module spi_req_arbiter
    import spi_arb_pkg::*;
#(
    parameter int ADDR_W          = 7,
    parameter int DATA_W          = 8,
    parameter int MAX_GAIN_STREAK = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gain_req,
    input  logic [ADDR_W-1:0] gain_addr,
    input  logic [DATA_W-1:0] gain_wdata,
    input  logic              gain_wr,
    output logic              gain_grant,
    output logic              gain_done,
    output logic [DATA_W-1:0] gain_rdata,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    output logic              host_grant,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    output logic              m_start,
    output logic [ADDR_W-1:0] m_addr,
    output logic [DATA_W-1:0] m_wdata,
    output logic              m_wr,
    input  logic              m_done,
    input  logic [DATA_W-1:0] m_rdata
);
    logic   pick_valid;
    owner_t pick_owner;
    logic   take;
    logic   busy;
    owner_t owner_q;

    logic [NUM_SRC-1:0][ADDR_W-1:0] src_addr;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_wdata;
    logic [NUM_SRC-1:0]             src_wr;
    logic [NUM_SRC-1:0]             src_done;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_rdata;

    assign src_addr[OWN_GAIN]  = gain_addr;
    assign src_addr[OWN_HOST]  = host_addr;
    assign src_wdata[OWN_GAIN] = gain_wdata;
    assign src_wdata[OWN_HOST] = host_wdata;
    assign src_wr[OWN_GAIN]    = gain_wr;
    assign src_wr[OWN_HOST]    = host_wr;
    assign gain_done           = src_done[OWN_GAIN];
    assign host_done           = src_done[OWN_HOST];
    assign gain_rdata          = src_rdata[OWN_GAIN];
    assign host_rdata          = src_rdata[OWN_HOST];

    spi_arb_pick #(
        .MAX_GAIN_STREAK(MAX_GAIN_STREAK)
    ) u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .gain_req  (gain_req),
        .host_req  (host_req),
        .take      (take),
        .pick_valid(pick_valid),
        .pick_owner(pick_owner)
    );

    spi_arb_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick_valid(pick_valid),
        .pick_owner(pick_owner),
        .m_done    (m_done),
        .take      (take),
        .m_start   (m_start),
        .busy      (busy),
        .owner_q   (owner_q),
        .gain_grant(gain_grant),
        .host_grant(host_grant)
    );

    spi_arb_route #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .pick_owner(pick_owner),
        .owner_q   (owner_q),
        .busy      (busy),
        .src_addr  (src_addr),
        .src_wdata (src_wdata),
        .src_wr    (src_wr),
        .m_done    (m_done),
        .m_rdata   (m_rdata),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_wr      (m_wr),
        .src_done  (src_done),
        .src_rdata (src_rdata)
    );

    assert_grant_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(gain_grant && host_grant));

    assert_no_done_without_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!gain_grant && !host_grant) |-> (!gain_done && !host_done));

    assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gain_grant && !host_grant && !gain_req && !host_req && !m_start) |=> !m_start);

endmodule

// File: tb/spi_req_arbiter_tb.sv
module spi_req_arbiter_tb;
    localparam int AW  = 7;
    localparam int DW  = 8;
    localparam int CAP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gain_req = 1'b0, host_req = 1'b0;
    logic [AW-1:0] gain_addr = '0, host_addr = '0;
    logic [DW-1:0] gain_wdata = '0, host_wdata = '0;
    logic          gain_wr = 1'b0, host_wr = 1'b0;
    logic          gain_grant, host_grant, gain_done, host_done;
    logic [DW-1:0] gain_rdata, host_rdata;
    logic          m_start, m_wr;
    logic [AW-1:0] m_addr;
    logic [DW-1:0] m_wdata;
    logic          m_done = 1'b0;
    logic [DW-1:0] m_rdata = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    spi_req_arbiter #(.ADDR_W(AW), .DATA_W(DW), .MAX_GAIN_STREAK(CAP)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .gain_req(gain_req), .gain_addr(gain_addr), .gain_wdata(gain_wdata), .gain_wr(gain_wr),
        .gain_grant(gain_grant), .gain_done(gain_done), .gain_rdata(gain_rdata),
        .host_req(host_req), .host_addr(host_addr), .host_wdata(host_wdata), .host_wr(host_wr),
        .host_grant(host_grant), .host_done(host_done), .host_rdata(host_rdata),
        .m_start(m_start), .m_addr(m_addr), .m_wdata(m_wdata), .m_wr(m_wr),
        .m_done(m_done), .m_rdata(m_rdata)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Bench model: 0 idle, 1 launch, 2 busy, 3 release
    int  md_state = 0;
    int  md_owner = 0;
    int  md_streak = 0;
    int  cap_hits = 0;
    int  lat = 0;
    bit  gain_seen = 1'b0, host_seen = 1'b0;
    string pick_tag = "R2";

    function automatic int choose(input bit g, input bit h, input int streak);
        if (g && h) return (streak >= CAP) ? 1 : 0;
        return g ? 0 : 1;
    endfunction

    task automatic model_step();
        case (md_state)
            0: if (gain_req || host_req) begin
                md_owner = choose(gain_req, host_req, md_streak);
                if (gain_req && host_req) begin
                    pick_tag = (md_owner == 1) ? "R4" : "R3";
                    if (md_owner == 1) cap_hits++;
                end else pick_tag = "R2";
                md_streak = (md_owner == 0 && host_req) ? md_streak + 1 : 0;
                md_state = 1;
            end
            1: md_state = 2;
            2: if (m_done) md_state = 3;
            default: md_state = 0;
        endcase
    endtask

    task automatic drive(input int prob, input bit strays);
        if (md_state == 1) lat = $urandom % 4;
        if (md_state == 2) begin
            if (lat == 0) begin m_done = 1'b1; m_rdata = DW'($urandom); end
            else begin lat--; m_done = 1'b0; end
        end else begin
            m_done  = strays && ($urandom % 6 == 0);
            m_rdata = DW'($urandom);
        end
        if (gain_seen) begin gain_req = 1'b0; gain_seen = 1'b0; end
        else if (!gain_req && int'($urandom % 100) < prob) begin
            gain_req = 1'b1; gain_addr = AW'($urandom);
            gain_wdata = DW'($urandom); gain_wr = 1'($urandom);
        end
        if (host_seen) begin host_req = 1'b0; host_seen = 1'b0; end
        else if (!host_req && int'($urandom % 100) < prob) begin
            host_req = 1'b1; host_addr = AW'($urandom);
            host_wdata = DW'($urandom); host_wr = 1'($urandom);
        end
    endtask

    task automatic compare();
        bit exp_gg, exp_hg, exp_gd, exp_hd, stray;
        string ftag;
        exp_gg = (md_state == 1 || md_state == 2) && md_owner == 0;
        exp_hg = (md_state == 1 || md_state == 2) && md_owner == 1;
        ftag = (md_state == 1) ? pick_tag : (md_state == 2 ? "R5" : "R8");
        check({ftag, " gain_grant"}, 32'(gain_grant), 32'(exp_gg));
        check({ftag, " host_grant"}, 32'(host_grant), 32'(exp_hg));
        check("R2 m_start", 32'(m_start), 32'(md_state == 1));
        if (md_state == 1 || md_state == 2) begin
            check({ftag, " m_addr"},  32'(m_addr),  md_owner == 0 ? 32'(gain_addr)  : 32'(host_addr));
            check({ftag, " m_wdata"}, 32'(m_wdata), md_owner == 0 ? 32'(gain_wdata) : 32'(host_wdata));
            check({ftag, " m_wr"},    32'(m_wr),    md_owner == 0 ? 32'(gain_wr)    : 32'(host_wr));
        end
        stray  = m_done && md_state != 2;
        exp_gd = md_state == 2 && m_done && md_owner == 0;
        exp_hd = md_state == 2 && m_done && md_owner == 1;
        check(stray ? "R7 gain_done" : "R6 gain_done", 32'(gain_done), 32'(exp_gd));
        check(stray ? "R7 host_done" : "R6 host_done", 32'(host_done), 32'(exp_hd));
        check("R6 gain_rdata", 32'(gain_rdata), exp_gd ? 32'(m_rdata) : 32'h0);
        check("R6 host_rdata", 32'(host_rdata), exp_hd ? 32'(m_rdata) : 32'h0);
        if (gain_done) gain_seen = 1'b1;
        if (host_done) host_seen = 1'b1;
    endtask

    task automatic run_phase(input int cycles, input int prob, input bit strays);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            model_step();
            drive(prob, strays);
            #1;
            compare();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        gain_req = 1'b1; host_req = 1'b1; m_done = 1'b1;
        #1;
        check("R1 gain_grant in reset", 32'(gain_grant), 32'h0);
        check("R1 host_grant in reset", 32'(host_grant), 32'h0);
        check("R1 m_start in reset", 32'(m_start), 32'h0);
        check("R1 dones in reset", 32'({gain_done, host_done}), 32'h0);
        gain_req = 1'b0; host_req = 1'b0; m_done = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 grants after reset", 32'({gain_grant, host_grant}), 32'h0);
        check("R1 m_start after reset", 32'(m_start), 32'h0);

        // directed: lone host request
        @(negedge clk);
        host_req = 1'b1; host_addr = 7'h2A; host_wdata = 8'h5C; host_wr = 1'b1;
        run_phase(8, 0, 1'b0);
        // directed: both at once, dense
        run_phase(200, 100, 1'b0);
        run_phase(3000, 35, 1'b1);
        run_phase(400, 4, 1'b1);
        run_phase(1500, 100, 1'b1);
        run_phase(40, 0, 1'b0);
        check("R8 idle with no requests", 32'({gain_grant, host_grant, m_start}), 32'h0);
        check("R4 host won after gain streak", 32'(cap_hits > 0), 32'h1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule